// File: doc/BRIEF.md
# Two-Partition Flash Command and Status Unit

This block interprets command writes for a flash device whose array is split into two partitions. Each partition keeps its own read mode (array data or status byte) and its own 8-bit status register. A command write carries a partition index and a code. Only the addressed partition acts on it, so one partition can run or suspend an erase while the other keeps serving array reads.

A per-partition countdown timer stands in for the erase/program engine. It marks the partition busy for a fixed number of cycles. It can be frozen by a suspend and restarted by a resume. The programming-voltage-low input is sampled only when an operation finishes. Error flags stay set until the partition receives an explicit clear. The memory array is outside the block: on an array-mode read, the block passes on the data presented at `array_rdata_i`.

Top module: `flash_cmd_status`

## Requirements
- R1: A read (`rd_i` high for one cycle) returns its data on `rdata_o` with `rvalid_o` high in the next cycle. A partition in array mode returns `array_rdata_i`. A partition in status mode returns its status byte zero-extended. Both partitions leave reset in array mode with all status bits clear except ready.
- R2: A command or an engine event in one partition never changes the other partition's read mode or status.
- R3: Status byte layout:
  - bit 7: ready (1) / busy (0)
  - bit 6: erase suspended
  - bit 5: erase error
  - bit 4: program error
  - bit 3: voltage-low abort
  - bit 2: program suspended
  - bit 1: locked-block abort
  - bit 0: always 0
- R4: Bits 5, 4, 3 and 1 stay set until a Clear (0x50) reaches that partition while it is not busy. Clear zeroes those four bits of the addressed partition only and selects array mode, whatever the level of `vpp_low_i`.
- R5: Erase (0x20) or Program (0x40) on an idle partition selects status mode and keeps bit 7 at 0 for `OP_CYCLES` cycles, after which bit 7 returns to 1.
- R6: Suspend (0xB0) on a busy partition freezes the timer and sets bit 7, plus bit 6 for an erase or bit 2 for a program. Resume (0xD0) clears that flag, drops bit 7 and lets the remaining count run out.
- R7: Any code not listed in R4 to R11 sent to an idle partition sets bits 5 and 4 and selects array mode.
- R8: Erase or Program with `blk_locked_i`=1 and `wp_ni`=0 sets bit 1, selects status mode and does not start the engine. With `wp_ni`=1 the operation starts.
- R9: `vpp_low_i` is sampled only on the cycle an operation completes. If it is high then, bit 3 is set together with bit 5 (erase) or bit 4 (program). At any other time it has no effect.
- R10: While busy, only Read Status and Suspend are acted on. While suspended, Read Status, Read Array, Clear and Resume are acted on. Suspend and Resume on an idle partition change nothing.
- R11: Read Status (0x70) selects status mode and Read Array (0xFF) selects array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command write strobe |
| cmd_part_i | input | PART_W | Partition addressed by the command |
| cmd_code_i | input | 8 | Command code |
| wp_ni | input | 1 | Write protect, active low |
| blk_locked_i | input | 1 | Target block is locked |
| vpp_low_i | input | 1 | Programming voltage below threshold |
| rd_i | input | 1 | Read strobe |
| rd_part_i | input | PART_W | Partition addressed by the read |
| array_rdata_i | input | DATA_W | Data from the memory array |
| rdata_o | output | DATA_W | Read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
On every cycle, the assertions check that:
- reads answer one cycle later;
- read mode moves only on an addressed command;
- error bits never drop without an accepted clear;
- a clear leaves array mode with zeroed errors;
- the timer holds still while suspended;
- a locked-block abort never starts the engine.

Only the bench scenarios can show:
- the byte values actually returned;
- the partitions staying independent under interleaved traffic;
- the voltage input being sampled at completion and not before or after;
- commands being ignored while busy or suspended;
- the count resuming where it stopped.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam logic [7:0] CODE_RD_STATUS = 8'h70;
  localparam logic [7:0] CODE_CLEAR     = 8'h50;
  localparam logic [7:0] CODE_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CODE_SUSPEND   = 8'hB0;
  localparam logic [7:0] CODE_RESUME    = 8'hD0;
  localparam logic [7:0] CODE_ERASE     = 8'h20;
  localparam logic [7:0] CODE_PROGRAM   = 8'h40;

  typedef enum logic [2:0] {
    C_RD_STAT, C_CLEAR, C_RD_ARR, C_SUSP, C_RES, C_ERASE, C_PROG, C_BAD
  } cmd_e;

  typedef enum logic [1:0] {ENG_IDLE, ENG_BUSY, ENG_SUSP} eng_e;

  typedef enum logic {RM_ARRAY, RM_STATUS} rmode_e;

  // sticky error vector indices
  localparam int E_LOCK  = 0;
  localparam int E_VPP   = 1;
  localparam int E_PROG  = 2;
  localparam int E_ERASE = 3;
  localparam int ERR_W   = 4;

  localparam int SR_W = 8;

endpackage

// File: rtl/fcs_cmd_decode.sv
module fcs_cmd_decode
  import fcs_pkg::*;
(
  input  logic [7:0] code_i,
  output cmd_e       cmd_o
);

  always_comb begin
    case (code_i)
      CODE_RD_STATUS: cmd_o = C_RD_STAT;
      CODE_CLEAR:     cmd_o = C_CLEAR;
      CODE_RD_ARRAY:  cmd_o = C_RD_ARR;
      CODE_SUSPEND:   cmd_o = C_SUSP;
      CODE_RESUME:    cmd_o = C_RES;
      CODE_ERASE:     cmd_o = C_ERASE;
      CODE_PROGRAM:   cmd_o = C_PROG;
      default:        cmd_o = C_BAD;
    endcase
  end

endmodule

// File: rtl/fcs_op_timer.sv
module fcs_op_timer #(
  parameter int OP_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);

  localparam int CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (start_i)                 cnt_q <= CNT_W'(OP_CYCLES - 1);
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == '0);

  AST_TIMER_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !start_i) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/fcs_part.sv
module fcs_part
  import fcs_pkg::*;
#(
  parameter int OP_CYCLES = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hit_i,
  input  cmd_e            cmd_i,
  input  logic            wp_ni,
  input  logic            blk_locked_i,
  input  logic            vpp_low_i,
  output logic [SR_W-1:0] status_o,
  output logic            status_mode_o
);

  eng_e             eng_q, eng_d;
  rmode_e           mode_q, mode_d;
  logic             kind_erase_q, kind_erase_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic             susp_erase_q, susp_erase_d;
  logic             susp_prog_q, susp_prog_d;
  logic             start, done, run;
  logic             locked_abort, clr_accept;

  assign run          = (eng_q == ENG_BUSY);
  assign locked_abort = hit_i && (eng_q == ENG_IDLE) &&
                        (cmd_i == C_ERASE || cmd_i == C_PROG) && blk_locked_i && !wp_ni;
  assign clr_accept   = hit_i && (cmd_i == C_CLEAR) && (eng_q != ENG_BUSY);

  fcs_op_timer #(.OP_CYCLES(OP_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .run_i   (run),
    .done_o  (done)
  );

  always_comb begin
    eng_d        = eng_q;
    mode_d       = mode_q;
    kind_erase_d = kind_erase_q;
    err_d        = err_q;
    susp_erase_d = susp_erase_q;
    susp_prog_d  = susp_prog_q;
    start        = 1'b0;
    case (eng_q)
      ENG_IDLE: if (hit_i) begin
        case (cmd_i)
          C_RD_STAT: mode_d = RM_STATUS;
          C_RD_ARR:  mode_d = RM_ARRAY;
          C_CLEAR: begin
            err_d  = '0;
            mode_d = RM_ARRAY;
          end
          C_ERASE, C_PROG: begin
            mode_d = RM_STATUS;
            if (blk_locked_i && !wp_ni) begin
              err_d[E_LOCK] = 1'b1;
            end else begin
              eng_d        = ENG_BUSY;
              kind_erase_d = (cmd_i == C_ERASE);
              start        = 1'b1;
            end
          end
          C_BAD: begin
            err_d[E_ERASE] = 1'b1;
            err_d[E_PROG]  = 1'b1;
            mode_d         = RM_ARRAY;
          end
          default: ;
        endcase
      end
      ENG_BUSY: begin
        if (hit_i && cmd_i == C_RD_STAT) mode_d = RM_STATUS;
        if (done) begin
          eng_d = ENG_IDLE;
          if (vpp_low_i) begin
            err_d[E_VPP] = 1'b1;
            if (kind_erase_q) err_d[E_ERASE] = 1'b1;
            else              err_d[E_PROG]  = 1'b1;
          end
        end else if (hit_i && cmd_i == C_SUSP) begin
          eng_d = ENG_SUSP;
          if (kind_erase_q) susp_erase_d = 1'b1;
          else              susp_prog_d  = 1'b1;
        end
      end
      ENG_SUSP: if (hit_i) begin
        case (cmd_i)
          C_RD_STAT: mode_d = RM_STATUS;
          C_RD_ARR:  mode_d = RM_ARRAY;
          C_CLEAR: begin
            err_d  = '0;
            mode_d = RM_ARRAY;
          end
          C_RES: begin
            eng_d        = ENG_BUSY;
            susp_erase_d = 1'b0;
            susp_prog_d  = 1'b0;
          end
          default: ;
        endcase
      end
      default: eng_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eng_q        <= ENG_IDLE;
      mode_q       <= RM_ARRAY;
      kind_erase_q <= 1'b0;
      err_q        <= '0;
      susp_erase_q <= 1'b0;
      susp_prog_q  <= 1'b0;
    end else begin
      eng_q        <= eng_d;
      mode_q       <= mode_d;
      kind_erase_q <= kind_erase_d;
      err_q        <= err_d;
      susp_erase_q <= susp_erase_d;
      susp_prog_q  <= susp_prog_d;
    end
  end

  assign status_o = {eng_q != ENG_BUSY, susp_erase_q, err_q[E_ERASE], err_q[E_PROG],
                     err_q[E_VPP], susp_prog_q, err_q[E_LOCK], 1'b0};
  assign status_mode_o = (mode_q == RM_STATUS);

  AST_SUSP_IMPLIES_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_erase_q || susp_prog_q) |-> (eng_q == ENG_SUSP)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_accept |=> ((err_q & $past(err_q)) == $past(err_q))); // R4
  AST_CLEAR_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_accept |=> (mode_q == RM_ARRAY && err_q == '0)); // R4
  AST_MODE_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(mode_q)); // R2
  AST_LOCK_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_abort |=> (eng_q == ENG_IDLE && err_q[E_LOCK])); // R8

endmodule

// File: rtl/fcs_read_path.sv
module fcs_read_path
  import fcs_pkg::*;
#(
  parameter int NUM_PART = 2,
  parameter int DATA_W   = 16,
  parameter int PART_W   = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_i,
  input  logic [PART_W-1:0]        rd_part_i,
  input  logic [DATA_W-1:0]        array_rdata_i,
  input  logic [NUM_PART*SR_W-1:0] status_i,
  input  logic [NUM_PART-1:0]      status_mode_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rvalid_o
);

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int p = 0; p < NUM_PART; p++) begin
      if (int'(rd_part_i) == p)
        sel = status_mode_i[p] ? DATA_W'(status_i[p*SR_W +: SR_W]) : array_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= sel;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o); // R1

endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
  import fcs_pkg::*;
#(
  parameter int NUM_PART  = 2,
  parameter int DATA_W    = 16,
  parameter int OP_CYCLES = 8,
  localparam int PART_W   = (NUM_PART > 1) ? $clog2(NUM_PART) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [PART_W-1:0] cmd_part_i,
  input  logic [7:0]        cmd_code_i,
  input  logic              wp_ni,
  input  logic              blk_locked_i,
  input  logic              vpp_low_i,
  input  logic              rd_i,
  input  logic [PART_W-1:0] rd_part_i,
  input  logic [DATA_W-1:0] array_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  cmd_e                     cmd;
  logic [NUM_PART*SR_W-1:0] status_flat;
  logic [NUM_PART-1:0]      status_mode;

  fcs_cmd_decode u_dec (
    .code_i (cmd_code_i),
    .cmd_o  (cmd)
  );

  for (genvar p = 0; p < NUM_PART; p++) begin : g_part
    localparam logic [PART_W-1:0] IDX = PART_W'(p);
    logic hit;
    assign hit = cmd_valid_i && (cmd_part_i == IDX);

    fcs_part #(.OP_CYCLES(OP_CYCLES)) u_part (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .hit_i         (hit),
      .cmd_i         (cmd),
      .wp_ni         (wp_ni),
      .blk_locked_i  (blk_locked_i),
      .vpp_low_i     (vpp_low_i),
      .status_o      (status_flat[p*SR_W +: SR_W]),
      .status_mode_o (status_mode[p])
    );
  end

  fcs_read_path #(
    .NUM_PART (NUM_PART),
    .DATA_W   (DATA_W),
    .PART_W   (PART_W)
  ) u_rd (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_i          (rd_i),
    .rd_part_i     (rd_part_i),
    .array_rdata_i (array_rdata_i),
    .status_i      (status_flat),
    .status_mode_i (status_mode),
    .rdata_o       (rdata_o),
    .rvalid_o      (rvalid_o)
  );

endmodule

// File: tb/flash_cmd_status_tb.sv
module flash_cmd_status_tb;

  localparam int OPC = 8;
  localparam logic [15:0] ARR = 16'hA5C3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [0:0]  cmd_part_i = '0;
  logic [7:0]  cmd_code_i = '0;
  logic        wp_ni = 1'b1;
  logic        blk_locked_i = 1'b0;
  logic        vpp_low_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [0:0]  rd_part_i = '0;
  logic [15:0] array_rdata_i = ARR;
  logic [15:0] rdata_o;
  logic        rvalid_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk_i = ~clk_i;

  flash_cmd_status #(.NUM_PART(2), .DATA_W(16), .OP_CYCLES(OPC)) u_dut (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_part_i, .cmd_code_i, .wp_ni,
    .blk_locked_i, .vpp_low_i, .rd_i, .rd_part_i, .array_rdata_i,
    .rdata_o, .rvalid_o
  );

  task automatic cmd(input int p, input logic [7:0] code);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_part_i = 1'(p); cmd_code_i = code;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic rd(input int p, input logic [15:0] exp, input string tag);
    @(negedge clk_i);
    rd_i = 1'b1; rd_part_i = 1'(p);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R1 unexpected read data: actual %h expected none", rdata_o);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata_o !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, rdata_o, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    // reset state
    rd(0, ARR, "R1 reset p0 array mode");
    rd(1, ARR, "R1 reset p1 array mode");
    cmd(0, 8'h70); rd(0, 16'h0080, "R11 R3 p0 status after reset");
    cmd(1, 8'h70); rd(1, 16'h0080, "R11 R3 p1 status after reset");
    cmd(0, 8'hFF); cmd(1, 8'hFF);
    rd(0, ARR, "R11 read array restores p0");

    // unknown code
    cmd(0, 8'h12); rd(0, ARR, "R7 bad code selects array");
    cmd(0, 8'h70); rd(0, 16'h00B0, "R7 bad code sets bits 5 and 4");
    cmd(1, 8'h70); rd(1, 16'h0080, "R2 p1 untouched by p0 error");

    // clear with voltage low
    vpp_low_i = 1'b1;
    cmd(0, 8'h50); rd(0, ARR, "R4 clear selects array");
    vpp_low_i = 1'b0;
    cmd(0, 8'h70); rd(0, 16'h0080, "R4 clear zeroes errors");

    // stickiness and partition-local clear
    cmd(1, 8'h99); cmd(1, 8'hFF); cmd(1, 8'h70);
    rd(1, 16'h00B0, "R4 error survives other commands");
    cmd(0, 8'h50);
    rd(1, 16'h00B0, "R4 R2 clear on p0 leaves p1 errors");
    cmd(1, 8'h50);
    rd(1, ARR, "R4 p1 clear to array");

    // erase, ignored commands while busy
    cmd(0, 8'h20); rd(0, 16'h0000, "R5 erase busy in status mode");
    cmd(0, 8'hFF); cmd(0, 8'h50);
    rd(0, 16'h0000, "R10 read array and clear ignored while busy");
    rd(1, ARR, "R2 p1 array during p0 erase");
    idle(OPC + 4);
    rd(0, 16'h0080, "R5 erase completes ready");

    // voltage sampled only at completion
    vpp_low_i = 1'b1;
    cmd(0, 8'h40); idle(OPC + 4);
    rd(0, 16'h0098, "R9 low voltage at end of program");
    vpp_low_i = 1'b0;
    cmd(0, 8'h50); cmd(0, 8'h70);
    vpp_low_i = 1'b1;
    cmd(0, 8'h40);
    vpp_low_i = 1'b0;
    idle(OPC + 4);
    rd(0, 16'h0080, "R9 low voltage at start only ignored");
    vpp_low_i = 1'b1; idle(3);
    rd(0, 16'h0080, "R9 low voltage while idle ignored");
    vpp_low_i = 1'b0;

    // locked block
    blk_locked_i = 1'b1; wp_ni = 1'b0;
    cmd(0, 8'h20); rd(0, 16'h0082, "R8 locked abort sets bit 1 no busy");
    cmd(0, 8'h50); rd(0, ARR, "R8 clear after lock abort");
    wp_ni = 1'b1;
    cmd(0, 8'h40); rd(0, 16'h0000, "R8 locked with wp high proceeds");
    idle(OPC + 4);
    rd(0, 16'h0080, "R8 unlocked-by-wp program completes");
    blk_locked_i = 1'b0;

    // erase suspend / resume
    cmd(0, 8'h20); idle(2);
    cmd(0, 8'hB0); rd(0, 16'h00C0, "R6 erase suspend sets 7 and 6");
    cmd(0, 8'hFF); rd(0, ARR, "R10 read array while suspended");
    cmd(0, 8'h70); idle(20);
    rd(0, 16'h00C0, "R6 timer frozen while suspended");
    cmd(0, 8'hD0); rd(0, 16'h0000, "R6 resume clears flag and busy");
    idle(OPC + 4);
    rd(0, 16'h0080, "R6 resumed erase completes");

    // program suspend
    cmd(0, 8'h40);
    cmd(0, 8'hB0); rd(0, 16'h0084, "R6 program suspend sets 7 and 2");
    cmd(0, 8'h20); rd(0, 16'h0084, "R10 erase ignored while suspended");
    cmd(0, 8'hD0); idle(OPC + 4);
    rd(0, 16'h0080, "R6 resumed program completes");

    // suspend on idle partition
    cmd(1, 8'hB0); rd(1, ARR, "R10 suspend on idle p1 no effect");
    cmd(1, 8'h70); rd(1, 16'h0080, "R3 p1 status clean at end");

    idle(4);
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R1 missing reads: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule